// File: doc/BRIEF.md
# Initial Access Latency Timer

This block times the gap between the end of the command-address phase and the first data beat on a double-data-rate memory link with a strobe pin that also signals refresh contention. When the controller finishes shifting out the command-address words it pulses `start` for one cycle. On that same edge the timer samples three things: a 4-bit latency selector, a mode bit and the strobe level that the memory drove during command-address. From these it forms a wait length in clocks, counts it down, and raises `done` for one cycle when the wait has passed.

The selector is sparse. Only four of its sixteen values are defined. Any other value is flagged on `bad_code` and treated as the 6-clock setting. In fixed mode the wait is always twice the selected latency. In variable mode the strobe level picks either the single or the doubled latency. A fresh `start` abandons any count in progress.

Top module: `latency_timer`

## Requirements
- R1: A selector of 0000 gives a base latency of 5 clocks, and 0001 gives 6 clocks.
- R2: A selector of 1110 gives a base latency of 3 clocks, and 1111 gives 4 clocks.
- R3: Selectors 0010 through 1101 drive `bad_code` high from the cycle after `start` and use a base latency of 6 clocks. The four defined selectors drive `bad_code` low.
- R4: With `fixed_en` = 1 the wait is twice the base latency, whatever the level on `ca_rwds`.
- R5: With `fixed_en` = 0 the wait is twice the base latency when `ca_rwds` is 1 and equal to the base latency when `ca_rwds` is 0.
- R6: If `start` is sampled high at clock edge k, `done` is low after edge k and goes high after edge k+N, where N is the wait. It stays high for exactly one cycle.
- R7: A `start` that arrives while a count is running begins a new count with the newly sampled inputs. The abandoned count never produces `done`.
- R8: After reset `done` and `bad_code` are low. `bad_code` holds its value from one `start` to the next.
- R9: `lat_code`, `fixed_en` and `ca_rwds` are ignored in every cycle where `start` is low. Changing them during a count alters neither the count nor `bad_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse marking the end of command-address |
| lat_code | input | CODE_W (4) | Latency selector |
| fixed_en | input | 1 | 1: always use the doubled latency. 0: the strobe level decides |
| ca_rwds | input | 1 | Strobe level sampled during command-address |
| done | output | 1 | One-cycle pulse when the wait has elapsed |
| bad_code | output | 1 | The last sampled selector was undefined |

## Verification
The downcounter and its busy flag can only be seen through the timing of `done`. A count loaded with the wrong value, or a busy flag that clears too early or too late, moves the pulse by at least one cycle, and the error shows up within twelve cycles of `start`. Measuring the exact delay for every selector and mode combination therefore catches a decoder or scaling fault on the first transfer that uses that combination. A busy flag that never clears shows up as a `done` lasting two cycles. A count that survives a restart shows up as a spurious `done` in the quiet window that follows the restarted count.

// File: rtl/lat_pkg.sv
package lat_pkg;
  localparam int CODE_W = 4;
  localparam int BASE_W = 3;
  localparam logic [BASE_W-1:0] FALLBACK_BASE = 3'd6;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic              invalid;
  } lat_dec_t;
endpackage

// File: rtl/lat_decode.sv
module lat_decode #(
  parameter int CODE_W = lat_pkg::CODE_W,
  parameter int BASE_W = lat_pkg::BASE_W
) (
  input  logic [CODE_W-1:0] code,
  output logic [BASE_W-1:0] base,
  output logic              invalid
);
  localparam logic [CODE_W-1:0] C_ZERO = '0;
  localparam logic [CODE_W-1:0] C_ONE  = CODE_W'(1);
  localparam logic [CODE_W-1:0] C_TOP  = '1;
  localparam logic [CODE_W-1:0] C_TOPM = C_TOP - CODE_W'(1);

  always_comb begin
    invalid = 1'b0;
    if (code == C_ZERO)      base = BASE_W'(5);
    else if (code == C_ONE)  base = BASE_W'(6);
    else if (code == C_TOPM) base = BASE_W'(3);
    else if (code == C_TOP)  base = BASE_W'(4);
    else begin
      base    = BASE_W'(lat_pkg::FALLBACK_BASE);
      invalid = 1'b1;
    end
  end
endmodule

// File: rtl/lat_scale.sv
module lat_scale #(
  parameter int BASE_W = lat_pkg::BASE_W,
  localparam int CNT_W = BASE_W + 1
) (
  input  logic [BASE_W-1:0] base,
  input  logic              fixed_en,
  input  logic              ca_rwds,
  output logic [CNT_W-1:0]  target
);
  logic dbl;
  always_comb begin
    dbl    = fixed_en | ca_rwds;
    target = dbl ? {base, 1'b0} : {1'b0, base};
  end
endmodule

// File: rtl/lat_counter.sv
module lat_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] target,
  output logic             done
);
  logic [CNT_W-1:0] remain;
  logic             busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        remain <= target - CNT_W'(1);
        busy   <= 1'b1;
      end else if (busy) begin
        if (remain == '0) begin
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          remain <= remain - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/latency_timer.sv
module latency_timer #(
  parameter int CODE_W = lat_pkg::CODE_W,
  parameter int BASE_W = lat_pkg::BASE_W,
  localparam int CNT_W = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] lat_code,
  input  logic              fixed_en,
  input  logic              ca_rwds,
  output logic              done,
  output logic              bad_code
);
  lat_pkg::lat_dec_t dec;
  logic [CNT_W-1:0]  target;

  lat_decode #(.CODE_W(CODE_W), .BASE_W(BASE_W)) u_dec (
    .code    (lat_code),
    .base    (dec.base),
    .invalid (dec.invalid)
  );

  lat_scale #(.BASE_W(BASE_W)) u_scale (
    .base     (dec.base),
    .fixed_en (fixed_en),
    .ca_rwds  (ca_rwds),
    .target   (target)
  );

  lat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (start),
    .target (target),
    .done   (done)
  );

  always_ff @(posedge clk) begin
    if (rst)        bad_code <= 1'b0;
    else if (start) bad_code <= dec.invalid;
  end
endmodule

// File: rtl/lat_timer_chk.sv
module lat_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [3:0] lat_code,
  input logic       fixed_en,
  input logic       ca_rwds,
  input logic       done,
  input logic       bad_code
);
  logic       code_ok;
  logic [4:0] elapsed;
  logic [4:0] want;
  logic       armed;
  logic [4:0] base_now;

  always_comb begin
    code_ok = (lat_code == 4'd0) || (lat_code == 4'd1) ||
              (lat_code == 4'd14) || (lat_code == 4'd15);
    case (lat_code)
      4'd0:    base_now = 5'd5;
      4'd14:   base_now = 5'd3;
      4'd15:   base_now = 5'd4;
      default: base_now = 5'd6;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
      want    <= '0;
      armed   <= 1'b0;
    end else if (start) begin
      elapsed <= '0;
      want    <= (fixed_en | ca_rwds) ? (base_now << 1) : base_now;
      armed   <= 1'b1;
    end else if (armed) begin
      if (done) armed <= 1'b0;
      if (elapsed != 5'd31) elapsed <= elapsed + 5'd1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!done && !bad_code)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
  AST_NO_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> !done); // R7
  AST_BAD_FLAG_SET: assert property (@(posedge clk) disable iff (rst) (start && !code_ok) |=> bad_code); // R3
  AST_BAD_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst) (start && code_ok) |=> !bad_code); // R3
  AST_BAD_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(bad_code)); // R9
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (rst) done |-> (armed && elapsed == want)); // R6
endmodule

bind latency_timer lat_timer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .lat_code (lat_code),
  .fixed_en (fixed_en),
  .ca_rwds  (ca_rwds),
  .done     (done),
  .bad_code (bad_code)
);

// File: tb/latency_timer_test.sv
module latency_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] lat_code = 4'd1;
  logic       fixed_en = 1'b1;
  logic       ca_rwds = 1'b0;
  logic       done;
  logic       bad_code;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latency_timer uut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lat_code (lat_code),
    .fixed_en (fixed_en),
    .ca_rwds  (ca_rwds),
    .done     (done),
    .bad_code (bad_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int base_of(input logic [3:0] c);
    if (c == 4'd0)  return 5;
    if (c == 4'd1)  return 6;
    if (c == 4'd14) return 3;
    if (c == 4'd15) return 4;
    return 6;
  endfunction

  task automatic run_case(input logic [3:0] c, input logic f, input logic r, input bit wiggle);
    int  exp_n;
    int  n;
    bit  exp_bad;
    string tag;
    exp_bad = !(c == 4'd0 || c == 4'd1 || c == 4'd14 || c == 4'd15);
    exp_n   = (f || r) ? 2 * base_of(c) : base_of(c);
    tag = (c <= 4'd1) ? "R1" : (c >= 4'd14) ? "R2" : "R3";
    @(negedge clk);
    lat_code = c; fixed_en = f; ca_rwds = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R6 done low after start edge", int'(done), 0);
    chk(bad_code == exp_bad, "R3 bad_code after start", int'(bad_code), int'(exp_bad));
    if (wiggle) begin
      lat_code = ~c; fixed_en = ~f; ca_rwds = ~r;
    end
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp_n, {tag, (f ? " R4" : " R5"), (wiggle ? " R9" : ""), " wait length"}, n, exp_n);
    @(negedge clk);
    chk(done == 1'b0, "R6 done lasts one cycle", int'(done), 0);
    chk(bad_code == exp_bad, "R8 bad_code held", int'(bad_code), int'(exp_bad));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R8 reset done", int'(done), 0);
    chk(bad_code == 1'b0, "R8 reset bad_code", int'(bad_code), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int c = 0; c < 16; c++)
      for (int m = 0; m < 4; m++)
        run_case(4'(c), m[1], m[0], m[1]);

    // R7: restart a 12-cycle wait with a 3-cycle one
    @(negedge clk);
    lat_code = 4'd1; fixed_en = 1'b1; ca_rwds = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    lat_code = 4'd14; fixed_en = 1'b0; ca_rwds = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R7 no done at restart", int'(done), 0);
    n = 0;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R7 restarted wait length", n, 3);
    n = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (done) n++;
    end
    chk(n == 0, "R7 abandoned count silent", n, 0);

    // R3 then R8: reserved selector, then reset clears flag
    run_case(4'd7, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(bad_code == 1'b0, "R8 reset clears bad_code", int'(bad_code), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule